// File: doc/BRIEF.md
# Receive Interrupt Coalescer

This block cuts the number of receive interrupts a host sees. It watches two per-packet completion pulses, one fired when a frame lands in local packet memory and one fired when it lands in host memory. A configuration bit picks which of the two counts as "packet done". Completed packets are counted. A single sticky interrupt flag is raised when the count reaches a programmable threshold of 1, 2, 4 or 8 packets. It is also raised when a programmable timeout runs out after the most recent counted packet, whichever comes first.

The timeout is a 16-bit value supplied as two byte-wide configuration inputs. It advances on a slow periodic `tick` strobe, for example a 25 MHz enable derived from the core clock. A value of zero turns the timeout off. With threshold code 0 and timeout 0 the block raises the flag for every packet. The flag stays set until software pulses the clear input.

Control is a two-state machine. `ST_IDLE` means no packets are pending and the timer is held at zero. `ST_PEND` means at least one counted packet is waiting to be reported. The transitions are:
- IDLE_TO_PEND: a counted completion arrives and does not by itself reach the threshold.
- IDLE_STAY: no completion arrives, or a completion reaches a threshold of 1.
- PEND_TO_IDLE: an interrupt fires, by count or by timeout.
- PEND_STAY: no interrupt fires.

Top module: `rx_irq_coalescer`

## Requirements
- R1: After reset `irq_flag` is 0, the packet count is 0 and the machine is in `ST_IDLE` with the timer stopped.
- R2: `count_code` selects the packets per interrupt: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8. The flag sets on the clock edge that samples the completion which makes the count equal the threshold.
- R3: The timeout value is `{tmo_hi, tmo_lo}`, so `tmo_hi[7]` is bit 15 and `tmo_lo[0]` is bit 0. A value of 0 disables the timeout entirely.
- R4: With a non-zero timeout T and packets pending, the flag sets on the edge that samples the T-th `tick` since the last counted completion. This happens even if the count threshold was not reached.
- R5: Every counted completion restarts the timer from zero. While nothing is pending the timer does not advance, whatever `tick` does.
- R6: With `sel_host`=0 only `local_done` is counted, and with `sel_host`=1 only `host_done` is counted. The other pulse has no effect.
- R7: When an interrupt fires, for either cause, the packet count and the timer both return to zero and the machine returns to `ST_IDLE`.
- R8: `irq_flag` stays set until `irq_clr` is high on a clock edge. A completion on the clear cycle is counted toward the next interrupt. If an interrupt fires on the clear cycle, the flag stays set.
- R9: If the count reaches its threshold on the same edge the timer expires, exactly one interrupt is generated and nothing remains pending.
- R10: With `count_code`=0 and timeout 0, every counted completion sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer step enable, one cycle per timer increment |
| local_done | input | 1 | Pulse: a packet finished moving into local packet memory |
| host_done | input | 1 | Pulse: a packet finished moving into host memory |
| sel_host | input | 1 | Completion source: 0 local, 1 host |
| count_code | input | 2 | Packet-count threshold code |
| tmo_hi | input | 8 | Timeout value bits 15..8 |
| tmo_lo | input | 8 | Timeout value bits 7..0 |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky receive interrupt status |

## Verification
A count that is off by one shows at the port as a flag that sets one completion early or late. A count left over from an earlier interrupt shows as a flag that sets too soon on the next burst. Both become visible one edge after the completion that should or should not have fired. A timer that is not restarted, or that runs while nothing is pending, shows as a flag that sets several ticks early or from a quiet link. The bench therefore counts ticks precisely on both sides of each expiry. Clear-cycle races are visible within one cycle of the clear.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
    // Width of the packet-count threshold code
    localparam int CODE_W   = 2;
    // Largest threshold the code can select (1 << (2^CODE_W - 1))
    localparam int MAX_PKTS = 1 << ((1 << CODE_W) - 1);
    // Counter width able to hold MAX_PKTS
    localparam int CNT_W    = $clog2(MAX_PKTS) + 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } rxc_state_e;

    // Code to packets-per-interrupt: 0->1, 1->2, 2->4, 3->8
    function automatic logic [CNT_W-1:0] code_to_thresh(input logic [CODE_W-1:0] code);
        return CNT_W'(1) << code;
    endfunction
endpackage

// File: rtl/rxc_src_sel.sv
module rxc_src_sel (
    input  logic sel_host,
    input  logic local_done,
    input  logic host_done,
    output logic evt
);
    // Only the chosen completion point counts; the other pulse is dropped
    always_comb begin
        evt = sel_host ? host_done : local_done;
    end
endmodule

// File: rtl/rxc_pkt_count.sv
module rxc_pkt_count
    import rxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              fire,
    input  logic [CODE_W-1:0] code,
    output logic              at_thresh
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] thresh;

    always_comb begin
        thresh    = code_to_thresh(code);
        cnt_inc   = cnt + CNT_W'(1);
        // >= so a threshold lowered while packets wait fires on the next packet
        at_thresh = evt && (cnt_inc >= thresh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (fire) begin
            cnt <= '0;
        end else if (evt) begin
            cnt <= cnt_inc;
        end
    end

    // R7
    fire_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt == '0));

    // R2
    evt_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !fire) |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/rxc_tmo_timer.sv
module rxc_tmo_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pending,
    input  logic             evt,
    input  logic             fire,
    input  logic [TMO_W-1:0] tmo,
    output logic             expire
);
    logic [TMO_W-1:0] tmr;
    logic [TMO_W:0]   tmr_nxt;
    logic             tmo_en;

    always_comb begin
        tmo_en  = |tmo;
        tmr_nxt = {1'b0, tmr} + (TMO_W+1)'(1);
        // Expire on the tick that brings the elapsed count to the limit
        expire  = pending && tick && tmo_en && (tmr_nxt >= {1'b0, tmo});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr <= '0;
        end else if (fire || evt || !pending) begin
            tmr <= '0;
        end else if (tick && tmo_en) begin
            tmr <= tmr_nxt[TMO_W-1:0];
        end
    end

    // R5
    evt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (tmr == '0));

    // R5
    idle_timer_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> (tmr == '0));
endmodule

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer
    import rxc_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              local_done,
    input  logic              host_done,
    input  logic              sel_host,
    input  logic [CODE_W-1:0] count_code,
    input  logic [BYTE_W-1:0] tmo_hi,
    input  logic [BYTE_W-1:0] tmo_lo,
    input  logic              irq_clr,
    output logic              irq_flag
);
    localparam int TMO_W = 2 * BYTE_W;

    rxc_state_e       state;
    rxc_state_e       state_nxt;
    logic             evt;
    logic             at_thresh;
    logic             expire;
    logic             fire;
    logic             pending;
    logic [TMO_W-1:0] tmo;

    always_comb begin
        tmo     = {tmo_hi, tmo_lo};
        pending = (state == ST_PEND);
        fire    = at_thresh || expire;
    end

    rxc_src_sel u_src (
        .sel_host   (sel_host),
        .local_done (local_done),
        .host_done  (host_done),
        .evt        (evt)
    );

    rxc_pkt_count u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .fire      (fire),
        .code      (count_code),
        .at_thresh (at_thresh)
    );

    rxc_tmo_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .pending (pending),
        .evt     (evt),
        .fire    (fire),
        .tmo     (tmo),
        .expire  (expire)
    );

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (evt && !fire) state_nxt = ST_PEND;  // IDLE_TO_PEND
            ST_PEND: if (fire)         state_nxt = ST_IDLE;  // PEND_TO_IDLE
            default:                   state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Output register: a new interrupt beats a clear on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_flag <= 1'b0;
        else if (fire)    irq_flag <= 1'b1;
        else if (irq_clr) irq_flag <= 1'b0;
    end

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R8
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !fire) |=> !irq_flag);

    // R7 R9
    fire_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state == ST_IDLE));

    // R4
    expire_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (state == ST_PEND));
endmodule

// File: tb/test_rx_irq_coalescer.sv
`timescale 1ns/1ps
module test_rx_irq_coalescer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       local_done = 1'b0;
    logic       host_done = 1'b0;
    logic       sel_host = 1'b0;
    logic [1:0] count_code = 2'd0;
    logic [7:0] tmo_hi = 8'd0;
    logic [7:0] tmo_lo = 8'd0;
    logic       irq_clr = 1'b0;
    logic       irq_flag;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;  // 125 MHz

    rx_irq_coalescer i_rx_irq_coalescer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .local_done (local_done),
        .host_done  (host_done),
        .sel_host   (sel_host),
        .count_code (count_code),
        .tmo_hi     (tmo_hi),
        .tmo_lo     (tmo_lo),
        .irq_clr    (irq_clr),
        .irq_flag   (irq_flag)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Stimulus table: sel, code, timeout, counted packets, ticks, expected flag
    localparam int NV = 14;
    localparam int V_SEL [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 1};
    localparam int V_CODE[NV] = '{0, 1, 1, 2, 2, 3, 3, 3, 3, 0, 0, 2, 3, 3};
    localparam int V_TMO [NV] = '{0, 0, 0, 0, 0, 0, 0, 5, 5, 0, 0, 0, 258, 258};
    localparam int V_NEV [NV] = '{1, 1, 2, 3, 4, 7, 8, 1, 1, 1, 0, 2, 1, 1};
    localparam int V_TCK [NV] = '{0, 0, 0, 0, 0, 0, 0, 4, 5, 0, 0, 100, 257, 258};
    localparam int V_EXP [NV] = '{1, 0, 1, 0, 1, 0, 1, 0, 1, 1, 0, 0, 0, 1};

    // Drive one cycle of inputs at the falling edge
    task automatic step(input logic l, input logic h, input logic t, input logic c);
        @(negedge clk);
        local_done = l;
        host_done  = h;
        tick       = t;
        irq_clr    = c;
    endtask

    // Idle cycle, then sample at the following falling edge
    task automatic settle();
        step(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // One counted completion on the selected source
    task automatic pkt();
        step(!sel_host, sel_host, 1'b0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        local_done = 1'b0; host_done = 1'b0; tick = 1'b0; irq_clr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: irq_flag actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic cfg(input logic s, input logic [1:0] c, input logic [15:0] t);
        sel_host   = s;
        count_code = c;
        tmo_hi     = t[15:8];
        tmo_lo     = t[7:0];
    endtask

    initial begin
        // R1: reset state
        do_reset();
        settle();
        check("R1 reset", irq_flag, 1'b0);

        // Table walk: R2 R3 R4 R6 R10
        for (int v = 0; v < NV; v++) begin
            do_reset();
            cfg(V_SEL[v] != 0, 2'(V_CODE[v]), 16'(V_TMO[v]));
            // Pulse on the unselected source first: must be ignored (R6)
            step(sel_host, !sel_host, 1'b0, 1'b0);
            for (int n = 0; n < V_NEV[v]; n++) begin
                step(sel_host, !sel_host, 1'b0, 1'b0);
                pkt();
            end
            ticks(V_TCK[v]);
            settle();
            check($sformatf("R2/R3/R4/R6/R10 vector %0d", v), irq_flag, V_EXP[v] != 0);
        end

        // R8: flag holds until cleared
        do_reset();
        cfg(1'b0, 2'd0, 16'd0);
        pkt();
        repeat (20) settle();
        check("R8 sticky", irq_flag, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        settle();
        check("R8 cleared", irq_flag, 1'b0);

        // R8: completion on the clear cycle counts toward the next interrupt
        cfg(1'b0, 2'd1, 16'd0);
        pkt(); pkt();
        settle();
        step(1'b1, 1'b0, 1'b0, 1'b1);
        settle();
        check("R8 clear-cycle event, flag low", irq_flag, 1'b0);
        pkt();
        settle();
        check("R8 clear-cycle event counted", irq_flag, 1'b1);

        // R8: interrupt firing on the clear cycle wins
        cfg(1'b0, 2'd0, 16'd0);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        settle();
        check("R8 fire beats clear", irq_flag, 1'b1);

        // R5: each packet restarts the timer
        do_reset();
        cfg(1'b0, 2'd3, 16'd5);
        pkt(); ticks(3); pkt(); ticks(3);
        settle();
        check("R5 restart, not yet", irq_flag, 1'b0);
        ticks(2);
        settle();
        check("R5 restart, expired", irq_flag, 1'b1);

        // R5: no pending packets, timer idle
        do_reset();
        cfg(1'b0, 2'd1, 16'd3);
        ticks(10);
        settle();
        check("R5 idle timer", irq_flag, 1'b0);

        // R7: timeout interrupt resets the counter
        pkt(); ticks(3);
        settle();
        check("R7 timeout fired", irq_flag, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        pkt();
        settle();
        check("R7 count reset after timeout", irq_flag, 1'b0);
        pkt();
        settle();
        check("R7 count restarts", irq_flag, 1'b1);

        // R9: count and timeout on the same edge give one interrupt
        do_reset();
        cfg(1'b0, 2'd1, 16'd1);
        pkt();
        step(1'b1, 1'b0, 1'b1, 1'b0);
        settle();
        check("R9 simultaneous fire", irq_flag, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        ticks(5);
        settle();
        check("R9 nothing pending", irq_flag, 1'b0);
        pkt();
        settle();
        check("R9 count cleared", irq_flag, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule